// File: doc/BRIEF.md
# Pulse Width and Period Measurement Timer

This block measures the time between chosen edges of a single asynchronous input. The count runs on a prescaled version of the system clock. The input is first brought into the clock domain through a two-stage synchronizer, and its rising and falling edges are then detected. A 3-bit mode field decides which edge starts a count and which edge ends it. The choices are:

- high pulse width
- low pulse width
- rising-to-rising period
- falling-to-falling period
- the gap between any two consecutive edges
- a period that spans several rising edges (input divider)

Two more mode codes turn the block into an interval timer. The timer counts up to a compare value, starts again from zero, and can toggle a pulse output each time it wraps.

Software sets the mode, the count style and the clock divider through one 8-bit control byte. A start strobe arms the block and a stop strobe aborts it. In single style the block returns to idle after one result. In continuous style it re-arms by itself, and every completed count is copied into the result buffer while the next count goes on. Two sticky flags report the state of the count. The done flag is set by each completed measurement or each timer wrap. The overflow flag is set when the counter wraps before the end edge arrives. Each flag has its own clear strobe.

Top module: `pulse_meas_timer`

## Requirements
- R1: After reset, result, done, ovf, pulseOut, busy and ctrlRdData are all zero.
- R2: The control byte layout is as follows: bits [2:0] are the mode, bit [3] is continuous (1) or single (0), bits [5:4] are reserved and always read as zero, and bits [7:6] are the clock select. ctrlRdData returns the stored byte.
- R3: Clock select 00 divides by 4, 01 by 16, 10 by 32, and 11 also by 32. A measurement over D system cycles between its two edges gives result = floor(D/divider).
- R4: Mode 101 measures from a rising edge to the next falling edge. Mode 110 measures from a falling edge to the next rising edge.
- R5: Mode 100 measures from rising edge to rising edge. Mode 111 measures from falling edge to falling edge.
- R6: Mode 010 measures between every two consecutive edges, of either polarity.
- R7: Mode 011 measures from one rising edge to the rising edge DIV_RATIO rising edges later.
- R8: In single style, busy drops after one result and no further done or result update follows until the next start.
- R9: In continuous style, every completed measurement writes result and sets done without a new start. In the period and any-edge modes, the end edge also begins the next count.
- R10: The ovf flag sets when the counter wraps during a measurement, and it stays set until ovfClr. The result then holds the wrapped count.
- R11: Mode 001 counts 0..cmp repeatedly whatever the style bit says. pulseOut toggles every (cmp+1)*divider cycles, and each wrap sets done.
- R12: Mode 000 sets done on reaching cmp and leaves pulseOut unchanged. In single style it then stops.
- R13: stopStrb returns the block to idle with no result. doneClr clears done.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| ctrlWrEn | input | 1 | Write strobe for the control byte |
| ctrlWrData | input | 8 | Control byte write data |
| ctrlRdData | output | 8 | Stored control byte |
| startStrb | input | 1 | Arm a measurement or start the timer |
| stopStrb | input | 1 | Abort and return to idle |
| cmpWrEn | input | 1 | Write strobe for the compare register |
| cmpWrData | input | CNT_W | Compare value for the timer modes |
| doneClr | input | 1 | Clear the done flag |
| ovfClr | input | 1 | Clear the overflow flag |
| sigIn | input | 1 | Asynchronous signal under measurement |
| result | output | CNT_W | Last completed measurement |
| done | output | 1 | Sticky completion flag |
| ovf | output | 1 | Sticky counter-wrap flag |
| pulseOut | output | 1 | Toggling timer output (mode 001) |
| busy | output | 1 | Block is armed, measuring or timing |

## Verification
The hardest case to reach from the ports is the counter wrapping inside a measurement. At the default width this would take hundreds of thousands of cycles. The bench therefore builds the block with a 10-bit counter and holds a high pulse for just over 1024 prescaled ticks, then checks both the sticky flag and the wrapped result. The other delicate case is a continuous period run, where one edge both ends a count and starts the next. The scoreboard queues a floor(D/divider) result for every gap driven and must see each one in order, with no extra or missing done pulses.

// File: rtl/pmt_pkg.sv
package pmt_pkg;
  typedef struct packed {
    logic clear;
    logic run;
    logic capture;
    logic timerMode;
    logic toggleEn;
  } pmtStrobe_t;

  typedef enum logic [1:0] {ST_IDLE, ST_ARM, ST_MEAS, ST_TIMER} pmtState_t;

  localparam logic [2:0] MODE_TIMER     = 3'b000;
  localparam logic [2:0] MODE_TIMER_OUT = 3'b001;
  localparam logic [2:0] MODE_ANY       = 3'b010;
  localparam logic [2:0] MODE_DIV       = 3'b011;
  localparam logic [2:0] MODE_RISE      = 3'b100;
  localparam logic [2:0] MODE_HIGH      = 3'b101;
  localparam logic [2:0] MODE_LOW       = 3'b110;
  localparam logic [2:0] MODE_FALL      = 3'b111;
endpackage

// File: rtl/pmt_ctrl.sv
module pmt_ctrl
  import pmt_pkg::*;
#(
  parameter int DIV_RATIO = 4,
  localparam int DIV_W = (DIV_RATIO > 2) ? $clog2(DIV_RATIO) : 1
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       sigIn,
  input  logic [2:0] mode,
  input  logic       contMode,
  input  logic       startStrb,
  input  logic       stopStrb,
  input  logic       cmpHit,
  output pmtStrobe_t strb,
  output logic       busy
);
  logic syncA, syncB, syncPrev;
  logic rise, fall;
  logic startEdge, stopEdge, restartOnStop;
  logic isTimer;
  logic [DIV_W-1:0] divCnt;
  logic divClr;
  pmtState_t state, nextState;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      syncA <= 1'b0;
      syncB <= 1'b0;
      syncPrev <= 1'b0;
    end else begin
      syncA <= sigIn;
      syncB <= syncA;
      syncPrev <= syncB;
    end
  end

  assign rise = syncB & ~syncPrev;
  assign fall = ~syncB & syncPrev;
  assign isTimer = (mode == MODE_TIMER) || (mode == MODE_TIMER_OUT);

  always_comb begin
    startEdge = 1'b0;
    stopEdge = 1'b0;
    restartOnStop = 1'b0;
    case (mode)
      MODE_ANY: begin
        startEdge = rise | fall;
        stopEdge = rise | fall;
        restartOnStop = 1'b1;
      end
      MODE_DIV: begin
        startEdge = rise;
        stopEdge = rise && (divCnt == DIV_W'(DIV_RATIO - 1));
        restartOnStop = 1'b1;
      end
      MODE_RISE: begin
        startEdge = rise;
        stopEdge = rise;
        restartOnStop = 1'b1;
      end
      MODE_FALL: begin
        startEdge = fall;
        stopEdge = fall;
        restartOnStop = 1'b1;
      end
      MODE_HIGH: begin
        startEdge = rise;
        stopEdge = fall;
      end
      MODE_LOW: begin
        startEdge = fall;
        stopEdge = rise;
      end
      default: ;
    endcase
  end

  always_comb begin
    strb = '0;
    nextState = state;
    divClr = 1'b0;
    case (state)
      ST_ARM: begin
        if (startEdge) begin
          strb.clear = 1'b1;
          divClr = 1'b1;
          nextState = ST_MEAS;
        end
      end
      ST_MEAS: begin
        strb.run = 1'b1;
        if (stopEdge) begin
          strb.capture = 1'b1;
          if (contMode && restartOnStop) begin
            strb.clear = 1'b1;
            divClr = 1'b1;
          end else if (contMode) begin
            nextState = ST_ARM;
          end else begin
            nextState = ST_IDLE;
          end
        end
      end
      ST_TIMER: begin
        strb.run = 1'b1;
        strb.timerMode = 1'b1;
        strb.toggleEn = (mode == MODE_TIMER_OUT);
        if (cmpHit && (mode == MODE_TIMER) && !contMode) nextState = ST_IDLE;
      end
      default: ;
    endcase
    if (stopStrb) begin
      strb = '0;
      nextState = ST_IDLE;
    end else if (startStrb) begin
      strb = '0;
      strb.clear = 1'b1;
      nextState = isTimer ? ST_TIMER : ST_ARM;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= ST_IDLE;
      divCnt <= '0;
    end else begin
      state <= nextState;
      if (divClr) divCnt <= '0;
      else if (state == ST_MEAS && rise && mode == MODE_DIV) divCnt <= divCnt + 1'b1;
    end
  end

  assign busy = (state != ST_IDLE);
endmodule

// File: rtl/pmt_datapath.sv
module pmt_datapath
  import pmt_pkg::*;
#(
  parameter int CNT_W = 16,
  parameter int PRE_W = 5
) (
  input  logic             clk,
  input  logic             rstN,
  input  pmtStrobe_t       strb,
  input  logic [1:0]       clkSel,
  input  logic             cmpWrEn,
  input  logic [CNT_W-1:0] cmpWrData,
  input  logic             doneClr,
  input  logic             ovfClr,
  output logic             cmpHit,
  output logic [CNT_W-1:0] result,
  output logic             done,
  output logic             ovf,
  output logic             pulseOut
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [PRE_W-1:0] preCnt, preLimit;
  logic [CNT_W-1:0] cnt, cmpReg;
  logic tick, wrapHit;

  always_comb begin
    case (clkSel)
      2'b00:   preLimit = PRE_W'(3);
      2'b01:   preLimit = PRE_W'(15);
      default: preLimit = PRE_W'(31);
    endcase
  end

  assign tick = strb.run && (preCnt == preLimit);
  assign cmpHit = tick && strb.timerMode && (cnt == cmpReg);
  assign wrapHit = tick && !strb.timerMode && (cnt == CNT_MAX);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      preCnt <= '0;
      cnt <= '0;
      cmpReg <= '0;
      result <= '0;
      done <= 1'b0;
      ovf <= 1'b0;
      pulseOut <= 1'b0;
    end else begin
      if (cmpWrEn) cmpReg <= cmpWrData;
      if (strb.clear) begin
        preCnt <= '0;
        cnt <= '0;
      end else if (strb.run) begin
        preCnt <= tick ? '0 : preCnt + 1'b1;
        if (cmpHit) cnt <= '0;
        else if (tick) cnt <= cnt + 1'b1;
      end
      if (strb.capture) result <= cnt + CNT_W'(tick);
      if (strb.capture || cmpHit) done <= 1'b1;
      else if (doneClr) done <= 1'b0;
      if (wrapHit) ovf <= 1'b1;
      else if (ovfClr) ovf <= 1'b0;
      if (cmpHit && strb.toggleEn) pulseOut <= ~pulseOut;
    end
  end
endmodule

// File: rtl/pulse_meas_timer.sv
module pulse_meas_timer
  import pmt_pkg::*;
#(
  parameter int CNT_W = 16,
  parameter int DIV_RATIO = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             ctrlWrEn,
  input  logic [7:0]       ctrlWrData,
  output logic [7:0]       ctrlRdData,
  input  logic             startStrb,
  input  logic             stopStrb,
  input  logic             cmpWrEn,
  input  logic [CNT_W-1:0] cmpWrData,
  input  logic             doneClr,
  input  logic             ovfClr,
  input  logic             sigIn,
  output logic [CNT_W-1:0] result,
  output logic             done,
  output logic             ovf,
  output logic             pulseOut,
  output logic             busy
);
  logic [7:0] ctrlReg;
  pmtStrobe_t strb;
  logic cmpHit;

  always_ff @(posedge clk) begin
    if (!rstN) ctrlReg <= 8'h00;
    else if (ctrlWrEn) ctrlReg <= {ctrlWrData[7:6], 2'b00, ctrlWrData[3:0]};
  end
  assign ctrlRdData = ctrlReg;

  pmt_ctrl #(.DIV_RATIO(DIV_RATIO)) i_ctrl (
    .clk(clk), .rstN(rstN), .sigIn(sigIn), .mode(ctrlReg[2:0]),
    .contMode(ctrlReg[3]), .startStrb(startStrb), .stopStrb(stopStrb),
    .cmpHit(cmpHit), .strb(strb), .busy(busy)
  );

  pmt_datapath #(.CNT_W(CNT_W)) i_datapath (
    .clk(clk), .rstN(rstN), .strb(strb), .clkSel(ctrlReg[7:6]),
    .cmpWrEn(cmpWrEn), .cmpWrData(cmpWrData), .doneClr(doneClr),
    .ovfClr(ovfClr), .cmpHit(cmpHit), .result(result), .done(done),
    .ovf(ovf), .pulseOut(pulseOut)
  );
endmodule

// File: rtl/pmt_checker.sv
module pmt_checker #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rstN,
  input logic             ctrlWrEn,
  input logic [7:0]       ctrlRdData,
  input logic             stopStrb,
  input logic             doneClr,
  input logic             ovfClr,
  input logic [CNT_W-1:0] result,
  input logic             done,
  input logic             ovf,
  input logic             pulseOut,
  input logic             busy
);
  a_r2_reserved_zero: assert property (@(posedge clk) disable iff (!rstN)
    ctrlRdData[5:4] == 2'b00);
  a_r9_done_sticky: assert property (@(posedge clk) disable iff (!rstN)
    (done && !doneClr) |=> done);
  a_r10_ovf_sticky: assert property (@(posedge clk) disable iff (!rstN)
    (ovf && !ovfClr) |=> ovf);
  a_r8_idle_result_held: assert property (@(posedge clk) disable iff (!rstN)
    !busy |=> $stable(result));
  a_r12_no_toggle_off_mode: assert property (@(posedge clk) disable iff (!rstN)
    (ctrlRdData[2:0] != 3'b001 && !ctrlWrEn) |=> $stable(pulseOut));
  a_r13_stop_idle: assert property (@(posedge clk) disable iff (!rstN)
    stopStrb |=> !busy);
endmodule

bind pulse_meas_timer pmt_checker #(.CNT_W(CNT_W)) i_pmt_checker (
  .clk(clk), .rstN(rstN), .ctrlWrEn(ctrlWrEn), .ctrlRdData(ctrlRdData),
  .stopStrb(stopStrb), .doneClr(doneClr), .ovfClr(ovfClr), .result(result),
  .done(done), .ovf(ovf), .pulseOut(pulseOut), .busy(busy)
);

// File: tb/test_pulse_meas_timer.sv
module test_pulse_meas_timer;
  localparam int CLK_PERIOD = 10;
  localparam int CW = 10;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic ctrlWrEn = 1'b0;
  logic [7:0] ctrlWrData = 8'h00;
  logic [7:0] ctrlRdData;
  logic startStrb = 1'b0;
  logic stopStrb = 1'b0;
  logic cmpWrEn = 1'b0;
  logic [CW-1:0] cmpWrData = '0;
  logic monClr = 1'b0;
  logic manClr = 1'b0;
  logic doneClr;
  logic ovfClr = 1'b0;
  logic sigIn = 1'b0;
  logic [CW-1:0] result;
  logic done, ovf, pulseOut, busy;
  logic monEn = 1'b1;
  int total = 0;
  int bad = 0;
  int expQ[$];
  string expTag[$];

  assign doneClr = monClr | manClr;

  always #(CLK_PERIOD/2) clk = ~clk;

  pulse_meas_timer #(.CNT_W(CW), .DIV_RATIO(4)) i_pulse_meas_timer (
    .clk(clk), .rstN(rstN), .ctrlWrEn(ctrlWrEn), .ctrlWrData(ctrlWrData),
    .ctrlRdData(ctrlRdData), .startStrb(startStrb), .stopStrb(stopStrb),
    .cmpWrEn(cmpWrEn), .cmpWrData(cmpWrData), .doneClr(doneClr),
    .ovfClr(ovfClr), .sigIn(sigIn), .result(result), .done(done),
    .ovf(ovf), .pulseOut(pulseOut), .busy(busy)
  );

  task automatic chk(input string req, input int got, input int exp);
    total++;
    if (got != exp) begin
      bad++;
      $display("FAIL %s: got %0d expected %0d", req, got, exp);
    end
  endtask

  task automatic push(input string req, input int value);
    expQ.push_back(value % (1 << CW));
    expTag.push_back(req);
  endtask

  task automatic hold(input logic level, input int cycles);
    sigIn = level;
    repeat (cycles) @(negedge clk);
  endtask

  task automatic setCtrl(input logic [7:0] value);
    ctrlWrData = value;
    ctrlWrEn = 1'b1;
    @(negedge clk);
    ctrlWrEn = 1'b0;
  endtask

  task automatic pulseStart();
    startStrb = 1'b1;
    @(negedge clk);
    startStrb = 1'b0;
  endtask

  task automatic pulseStop();
    stopStrb = 1'b1;
    @(negedge clk);
    stopStrb = 1'b0;
  endtask

  task automatic drain(input string req);
    repeat (20) @(negedge clk);
    chk({req, " all results seen"}, expQ.size(), 0);
    expQ.delete();
    expTag.delete();
  endtask

  // scoreboard monitor
  initial begin
    forever begin
      @(negedge clk);
      if (monClr) monClr = 1'b0;
      else if (monEn && done) begin
        if (expQ.size() == 0) begin
          total++;
          bad++;
          $display("FAIL R8/R9 unexpected result: got %0d expected none", result);
        end else begin
          chk(expTag.pop_front(), int'(result), expQ.pop_front());
        end
        monClr = 1'b1;
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog: got timeout expected finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [CW-1:0] held;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 result", int'(result), 0);
    chk("R1 done", int'(done), 0);
    chk("R1 ovf", int'(ovf), 0);
    chk("R1 pulseOut", int'(pulseOut), 0);
    chk("R1 busy", int'(busy), 0);
    chk("R1 ctrl", int'(ctrlRdData), 0);

    // R2 reserved bits read as zero
    setCtrl(8'hFF);
    chk("R2 readback", int'(ctrlRdData), 8'hCF);

    // R4 high width, div 4, single
    setCtrl(8'b00_00_0_101);
    sigIn = 1'b0; pulseStart(); repeat (4) @(negedge clk);
    push("R4 high width", 10);
    hold(1, 40); hold(0, 10);
    drain("R4");
    chk("R8 single idle", int'(busy), 0);

    // R4 low width, div 16
    setCtrl(8'b01_00_0_110);
    sigIn = 1'b1; repeat (4) @(negedge clk); pulseStart(); repeat (4) @(negedge clk);
    push("R4/R3 low width div16", 6);
    hold(0, 100); hold(1, 10);
    drain("R4");

    // R3 divide by 32 (code 10) and fallback code 11
    setCtrl(8'b10_00_0_101);
    sigIn = 1'b0; repeat (4) @(negedge clk); pulseStart(); repeat (4) @(negedge clk);
    push("R3 div32", 3);
    hold(1, 96); hold(0, 10);
    drain("R3");
    setCtrl(8'b11_00_0_101);
    pulseStart(); repeat (4) @(negedge clk);
    push("R3 code11 div32", 2);
    hold(1, 64); hold(0, 10);
    drain("R3");

    // R5/R9 rising period continuous
    setCtrl(8'b00_00_1_100);
    pulseStart(); repeat (4) @(negedge clk);
    push("R5/R9 rise period a", 5);
    push("R5/R9 rise period b", 9);
    hold(1, 8); hold(0, 12); hold(1, 16); hold(0, 20); hold(1, 6);
    drain("R9");
    chk("R9 still busy", int'(busy), 1);
    pulseStop();

    // R5 falling period continuous
    setCtrl(8'b00_00_1_111);
    sigIn = 1'b1; repeat (4) @(negedge clk); pulseStart(); repeat (4) @(negedge clk);
    push("R5 fall period a", 6);
    push("R5 fall period b", 7);
    hold(0, 10); hold(1, 14); hold(0, 8); hold(1, 20); hold(0, 6);
    drain("R5");
    pulseStop();

    // R6 any edge continuous
    setCtrl(8'b00_00_1_010);
    sigIn = 1'b0; repeat (4) @(negedge clk); pulseStart(); repeat (4) @(negedge clk);
    push("R6 gap a", 3); push("R6 gap b", 5); push("R6 gap c", 7);
    hold(1, 12); hold(0, 20); hold(1, 28); hold(0, 4);
    drain("R6");
    pulseStop();

    // R7 divided period, single
    setCtrl(8'b00_00_0_011);
    sigIn = 1'b0; repeat (4) @(negedge clk); pulseStart(); repeat (4) @(negedge clk);
    push("R7 divided period", 8);
    for (int i = 0; i < 4; i++) begin hold(1, 4); hold(0, 4); end
    hold(1, 4); hold(0, 4);
    drain("R7");

    // R8 single rising period: only one result
    setCtrl(8'b00_00_0_100);
    sigIn = 1'b0; pulseStart(); repeat (4) @(negedge clk);
    push("R8 single period", 5);
    hold(1, 10); hold(0, 10); hold(1, 15); hold(0, 15); hold(1, 10); hold(0, 4);
    drain("R8");
    chk("R8 busy low", int'(busy), 0);

    // R10 overflow with wrapped result
    setCtrl(8'b00_00_0_101);
    sigIn = 1'b0; pulseStart(); repeat (4) @(negedge clk);
    push("R10 wrapped result", 1030);
    hold(1, 4120); hold(0, 10);
    drain("R10");
    chk("R10 ovf set", int'(ovf), 1);
    repeat (5) @(negedge clk);
    chk("R10 ovf held", int'(ovf), 1);
    ovfClr = 1'b1; @(negedge clk); ovfClr = 1'b0;
    chk("R10 ovf cleared", int'(ovf), 0);

    // R13 stop aborts, doneClr cleared done
    chk("R13 done cleared", int'(done), 0);
    held = result;
    setCtrl(8'b00_00_0_101);
    pulseStart(); repeat (4) @(negedge clk);
    hold(1, 10); pulseStop(); hold(0, 20);
    chk("R13 busy after stop", int'(busy), 0);
    chk("R13 no result", int'(result), int'(held));
    chk("R13 no done", int'(done), 0);

    // R11 timer with pulse output
    monEn = 1'b0;
    cmpWrData = CW'(4); cmpWrEn = 1'b1; @(negedge clk); cmpWrEn = 1'b0;
    setCtrl(8'b00_00_0_001);
    pulseStart();
    repeat (10) @(negedge clk);
    chk("R11 pulse before wrap", int'(pulseOut), 0);
    repeat (20) @(negedge clk);
    chk("R11 pulse after 1 wrap", int'(pulseOut), 1);
    chk("R11 done on wrap", int'(done), 1);
    repeat (20) @(negedge clk);
    chk("R11 pulse after 2 wraps", int'(pulseOut), 0);
    chk("R11 keeps running", int'(busy), 1);
    pulseStop();
    manClr = 1'b1; @(negedge clk); manClr = 1'b0;

    // R12 plain timer, single
    cmpWrData = CW'(2); cmpWrEn = 1'b1; @(negedge clk); cmpWrEn = 1'b0;
    setCtrl(8'b00_00_0_000);
    pulseStart();
    repeat (8) @(negedge clk);
    chk("R12 done not yet", int'(done), 0);
    repeat (12) @(negedge clk);
    chk("R12 done", int'(done), 1);
    chk("R12 stopped", int'(busy), 0);
    chk("R12 pulse unchanged", int'(pulseOut), 0);
    manClr = 1'b1; @(negedge clk); manClr = 1'b0;
    chk("R13 doneClr", int'(done), 0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule